// File: doc/BRIEF.md
# Speculative Split Adder with Carry Prediction

This block adds two N-bit unsigned operands using two independent ripple adders of N/2 bits each, so the clock period only has to cover one half. The upper half does not wait for the lower half's carry. It takes its carry-in from a single stored guess bit. When the guess matches the real carry out of the lower half, the full sum is available in the first cycle after the operation starts.

When the guess is wrong, the block flags a miss and stalls new starts for that cycle. It replaces the guess with the real carry and recomputes the upper half from the held operands. The corrected result appears one cycle later. Because the guess is the last carry that was actually seen, runs of similar operands tend to complete in one cycle.

Only one operation is in flight at a time. Operands are captured on an accepted start and held until the result is delivered.

Top module: `spec_split_adder`

## Requirements
- R1: After reset, valid_o, miss_o and busy_o are 0, and the stored carry guess is 0. As a result, the first operation whose lower-half carry is 0 completes without a miss.
- R2: When start_i is accepted at an edge and the stored guess equals the carry out of the lower N/2 bits, the following cycle shows valid_o=1 and miss_o=0. In that same cycle, {cout_o,sum_o} equals the full (N+1)-bit sum of the operands.
- R3: When the stored guess differs from the lower-half carry, the first cycle after the start shows miss_o=1, busy_o=1 and valid_o=0.
- R4: The cycle after a miss cycle shows valid_o=1 and miss_o=0, with the correct sum_o and cout_o.
- R5: The stored guess is rewritten only in a miss cycle, where it takes the true lower-half carry. After a hit it keeps its value.
- R6: A start_i asserted while busy_o=1 is ignored. The pending result is delivered unchanged, and no further result follows from the ignored start.
- R7: valid_o is high for exactly one cycle per accepted operation. It is low when no operation is pending.
- R8: A start_i asserted in a hit cycle (busy_o=0) is accepted, and the new operation's result follows in the next cycle or the one after.
- R9: cout_o is the carry out of the upper half computed with the correct carry-in, i.e. bit N of the full sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start an addition with a_i, b_i (ignored while busy_o) |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| busy_o | output | 1 | Correction pending, starts refused this cycle |
| valid_o | output | 1 | sum_o and cout_o are final this cycle |
| miss_o | output | 1 | Carry guess was wrong this cycle |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry out of the full adder |

## Verification
The operand patterns are chosen so that the lower-half carry either agrees with or disagrees with the stored guess, in both directions: 0 after 0, 1 after 0, 1 after 1, and 0 after 1. This separates a correct one-cycle hit from a two-cycle correction, and shows whether the guess is updated only on a miss. Carries that cross the half boundary and overflow the full width (for example all ones plus one) test the upper-half recompute and the carry-out. Starts raised in a miss cycle test that such starts are ignored, and starts raised in a hit cycle test back-to-back acceptance.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_FIX  = 2'd2
  } spa_state_e;
endpackage

// File: rtl/spa_rca_half.sv
module spa_rca_half #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign cout_o = c[W];
endmodule

// File: rtl/spa_carry_pred.sv
module spa_carry_pred (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic carry_i,
  output logic pred_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pred_o <= 1'b0;
    else if (upd_i) pred_o <= carry_i;
  end
endmodule

// File: rtl/spa_ctrl.sv
module spa_ctrl
  import spa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hit_i,
  output logic load_o,
  output logic busy_o,
  output logic valid_o,
  output logic miss_o
);
  spa_state_e state_q, state_d;

  logic calc;
  assign calc    = (state_q == ST_CALC);
  assign miss_o  = calc & ~hit_i;
  assign busy_o  = miss_o;
  assign valid_o = (calc & hit_i) | (state_q == ST_FIX);
  assign load_o  = start_i & ~busy_o;

  always_comb begin
    if (load_o)      state_d = ST_CALC;
    else if (miss_o) state_d = ST_FIX;
    else             state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/spec_split_adder.sv
module spec_split_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             miss_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int HALF = WIDTH / 2;
  localparam int UPW  = WIDTH - HALF;

  logic [WIDTH-1:0] a_q, b_q;
  logic             load, pred_q, lo_cout, hit;
  logic [HALF-1:0]  lo_sum;
  logic [UPW-1:0]   hi_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  spa_rca_half #(.W(HALF)) i_lo (
    .a_i   (a_q[HALF-1:0]),
    .b_i   (b_q[HALF-1:0]),
    .cin_i (1'b0),
    .sum_o (lo_sum),
    .cout_o(lo_cout)
  );

  // upper half always runs on the stored guess; after a miss it holds the true carry
  spa_rca_half #(.W(UPW)) i_hi (
    .a_i   (a_q[WIDTH-1:HALF]),
    .b_i   (b_q[WIDTH-1:HALF]),
    .cin_i (pred_q),
    .sum_o (hi_sum),
    .cout_o(cout_o)
  );

  assign hit = (lo_cout == pred_q);

  spa_carry_pred i_pred (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (miss_o),
    .carry_i(lo_cout),
    .pred_o (pred_q)
  );

  spa_ctrl i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .hit_i  (hit),
    .load_o (load),
    .busy_o (busy_o),
    .valid_o(valid_o),
    .miss_o (miss_o)
  );

  assign sum_o = {hi_sum, lo_sum};
endmodule

// File: rtl/spec_split_adder_chk.sv
module spec_split_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic             miss_o,
  input logic             busy_o,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] a_q,
  input logic [WIDTH-1:0] b_q,
  input logic             pred_q
);
  // R2
  sum_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({cout_o, sum_o} == ({1'b0, a_q} + {1'b0, b_q})));

  // R4
  fix_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> (valid_o && !miss_o));

  // R5
  pred_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_o |=> $stable(pred_q));

  // R6
  no_double_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R7
  valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !miss_o);
endmodule

bind spec_split_adder spec_split_adder_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_spec_split_adder.sv
`timescale 1ns/1ps
module test_spec_split_adder;
  localparam int W = 16;
  localparam int H = W / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic busy, valid, miss, cout;
  logic [W-1:0] sum;
  int nvec = 0, nfail = 0;
  logic pred_m = 1'b0;

  always #10 clk = ~clk;

  spec_split_adder #(.WIDTH(W)) i_spec_split_adder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .busy_o(busy), .valid_o(valid), .miss_o(miss), .sum_o(sum), .cout_o(cout)
  );

  task automatic chk(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic lo_carry(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [H:0] t;
    t = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]};
    return t[H];
  endfunction

  // checks the result cycles of an op already registered; called at first negedge after load
  task automatic expect_result(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    logic [W:0] full;
    logic lc;
    full = {1'b0, x} + {1'b0, y};
    lc = lo_carry(x, y);
    if (lc == pred_m) begin
      chk(valid && !miss && !busy, {tag, " R2 hit flags"}, {valid, miss, busy}, 3'b100);
      chk({cout, sum} == full, {tag, " R2 R9 sum"}, {cout, sum}, full);
    end else begin
      chk(miss && busy && !valid, {tag, " R3 miss flags"}, {valid, miss, busy}, 3'b011);
      pred_m = lc;
      @(negedge clk);
      chk(valid && !miss, {tag, " R4 fix flags"}, {valid, miss}, 2'b10);
      chk({cout, sum} == full, {tag, " R4 R9 sum"}, {cout, sum}, full);
    end
  endtask

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    start = 1'b1; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    expect_result(x, y, tag);
    @(negedge clk);
    chk(!valid, {tag, " R7 single pulse"}, valid, 0);
  endtask

  task automatic t_reset();
    chk(!valid && !miss && !busy, "R1 reset flags", {valid, miss, busy}, 0);
    run_op(16'h0012, 16'h0034, "R1 first op");
  endtask

  task automatic t_ignore_busy();
    start = 1'b1; a = 16'h00FF; b = 16'h0001;
    @(negedge clk);
    chk(miss && busy, "R6 miss expected", {miss, busy}, 2'b11);
    a = 16'h1234; b = 16'h4321;
    @(negedge clk);
    start = 1'b0;
    pred_m = 1'b1;
    chk(valid && {cout, sum} == 17'h00100, "R6 pending result kept", {cout, sum}, 17'h00100);
    @(negedge clk);
    chk(!valid && !miss, "R6 ignored start no result", {valid, miss}, 0);
  endtask

  task automatic t_back2back();
    start = 1'b1; a = 16'h1080; b = 16'h0280;
    @(negedge clk);
    chk(valid && !busy, "R8 first hit", {valid, busy}, 2'b10);
    chk({cout, sum} == 17'h01300, "R8 first sum", {cout, sum}, 17'h01300);
    a = 16'h0101; b = 16'h0101;
    @(negedge clk);
    start = 1'b0;
    expect_result(16'h0101, 16'h0101, "R8 second");
    @(negedge clk);
    chk(!valid, "R7 idle after b2b", valid, 0);
  endtask

  initial begin
    #(200000 * 20);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(16'h00F0, 16'h0020, "R3 guess 0 carry 1");
    run_op(16'h01FF, 16'h0101, "R5 guess kept 1");
    run_op(16'hFFFF, 16'h0001, "R9 overflow");
    run_op(16'h8000, 16'h8000, "R3 guess 1 carry 0");
    run_op(16'h0007, 16'h0008, "R5 guess kept 0");
    t_ignore_busy();
    t_back2back();
    run_op(16'hABCD, 16'h5433, "R4 mixed");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule